// File: doc/BRIEF.md
# Dual-Source Stuck-Stream Health Monitor

This block watches the raw output of two noise sources. Each source delivers one bit per accepted sample. The block looks for the two ways such a stream commonly fails. The first is a long stretch of one repeated value. The second is a long stretch of one alternating two-bit pair repeated over and over.

The block applies two kinds of limit. Each source is judged on its own against generous limits. Both sources are also judged together against tighter limits, which fire only when both are stuck at the same time. Any hit latches a sticky seed-error status and emits a single-cycle notification. The surrounding entropy logic uses that notification to halt output and, during start-up, to restart initialization. Software-driven recovery clears the status and every counter with one strobe.

Sampling is qualified by an enable and a per-sample valid strobe. A sample is taken only when both are high. While the enable is low, all run state is held at its cleared value.

Top module: `rct_seed_monitor`

## Requirements
- R1: After reset, `seed_err` and `err_pulse` are both 0.
- R2: For each source, 65 consecutive accepted samples of equal value (0 or 1) raise `seed_err`. 64 such samples do not.
- R3: For each source, 33 back-to-back repeats of the pair 01 or of the pair 10 raise `seed_err`. 32 repeats do not. Pairs are built from accepted bits, and the first accepted bit after a clear is the first bit of a pair.
- R4: When every source is at the same time in a run of 33 or more equal bits, `seed_err` is raised. 32 such bits on every source do not raise it.
- R5: When every source is at the same time in a run of 17 or more repeats of 01 or 10, `seed_err` is raised. 16 such repeats do not raise it.
- R6: A single differing bit restarts that source's equal-value run count at 1.
- R7: `seed_err` stays 1 until `recover` is asserted. Asserting `recover` clears `seed_err` and all run and pair counts.
- R8: `err_pulse` is high for exactly one cycle, on the same cycle that `seed_err` rises. No further pulse occurs while `seed_err` stays 1.
- R9: A sample is accepted only when both `sample_valid` and `enable` are 1. A low `enable` clears all counts. While `enable` is low, no pulse is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Testing enable; low clears counters |
| recover | input | 1 | Recovery strobe; clears status and counters |
| sample_valid | input | 1 | Qualifies `sample_bits` this cycle |
| sample_bits | input | NUM_SRC (2) | One raw bit per source, bit 0 = source 0 |
| seed_err | output | 1 | Sticky seed-error status |
| err_pulse | output | 1 | One-cycle pulse on first detection |

## Verification
A miscounted run or a misaligned pair phase shows up at the ports as a `seed_err` that rises one sample too early or too late. The limits are therefore probed exactly at N and N+1 samples. The status appears two clock edges after the sample that crosses the limit. A counter that is not cleared by `recover`, by a low `enable`, or by a differing bit makes a later stream trip when it should not. A mis-built pulse shows up as a wrong cumulative pulse count across the whole run.

// File: rtl/rct_pkg.sv
package rct_pkg;

   // Flags one lane reports to the verdict stage
   typedef struct packed {
      logic run_single;   // equal-value run beyond the one-source limit
      logic run_joint;    // equal-value run beyond the all-source limit
      logic pat_single;   // pair repeats beyond the one-source limit
      logic pat_joint;    // pair repeats beyond the all-source limit
   } lane_flags_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rct_run_tracker.sv
module rct_run_tracker #(
   parameter int unsigned SINGLE_LIMIT = 64,
   parameter int unsigned JOINT_LIMIT  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic take,
   input  logic bit_in,
   output logic over_single,
   output logic over_joint
);
   localparam int unsigned CNT_W = $clog2(rct_pkg::max2(SINGLE_LIMIT, JOINT_LIMIT) + 2);
   localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SINGLE_LIMIT);
   localparam logic [CNT_W-1:0] LIM_J = CNT_W'(JOINT_LIMIT);

   logic             prev_bit;
   logic             have_prev;
   logic [CNT_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_bit  <= 1'b0;
         have_prev <= 1'b0;
         run_len   <= '0;
      end else if (clear) begin
         prev_bit  <= 1'b0;
         have_prev <= 1'b0;
         run_len   <= '0;
      end else if (take) begin
         prev_bit  <= bit_in;
         have_prev <= 1'b1;
         if (have_prev && (bit_in == prev_bit))
            run_len <= (&run_len) ? run_len : run_len + 1'b1;
         else
            run_len <= CNT_W'(1);
      end
   end

   assign over_single = (run_len > LIM_S);
   assign over_joint  = (run_len > LIM_J);
endmodule

// File: rtl/rct_pair_tracker.sv
module rct_pair_tracker #(
   parameter int unsigned SINGLE_LIMIT = 32,
   parameter int unsigned JOINT_LIMIT  = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic take,
   input  logic bit_in,
   output logic over_single,
   output logic over_joint
);
   localparam int unsigned CNT_W = $clog2(rct_pkg::max2(SINGLE_LIMIT, JOINT_LIMIT) + 2);
   localparam logic [CNT_W-1:0] LIM_S = CNT_W'(SINGLE_LIMIT);
   localparam logic [CNT_W-1:0] LIM_J = CNT_W'(JOINT_LIMIT);

   logic             second_half;   // phase toggle: 1 when next bit closes a pair
   logic             first_bit;
   logic [1:0]       last_pair;
   logic             have_pair;
   logic [CNT_W-1:0] rep_cnt;
   logic [1:0]       new_pair;
   logic             is_alt;

   assign new_pair = {first_bit, bit_in};
   assign is_alt   = new_pair[1] ^ new_pair[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         second_half <= 1'b0;
         first_bit   <= 1'b0;
         last_pair   <= 2'b00;
         have_pair   <= 1'b0;
         rep_cnt     <= '0;
      end else if (clear) begin
         second_half <= 1'b0;
         first_bit   <= 1'b0;
         last_pair   <= 2'b00;
         have_pair   <= 1'b0;
         rep_cnt     <= '0;
      end else if (take) begin
         second_half <= ~second_half;
         if (!second_half) begin
            first_bit <= bit_in;
         end else begin
            last_pair <= new_pair;
            have_pair <= 1'b1;
            if (!is_alt)
               rep_cnt <= '0;
            else if (have_pair && (new_pair == last_pair))
               rep_cnt <= (&rep_cnt) ? rep_cnt : rep_cnt + 1'b1;
            else
               rep_cnt <= CNT_W'(1);
         end
      end
   end

   assign over_single = (rep_cnt > LIM_S);
   assign over_joint  = (rep_cnt > LIM_J);
endmodule

// File: rtl/rct_lane.sv
module rct_lane
   import rct_pkg::*;
#(
   parameter int unsigned SINGLE_RUN_LIMIT = 64,
   parameter int unsigned JOINT_RUN_LIMIT  = 32,
   parameter int unsigned SINGLE_PAT_LIMIT = 32,
   parameter int unsigned JOINT_PAT_LIMIT  = 16,
   parameter bit          PAT_TEST_EN      = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        take,
   input  logic        bit_in,
   output lane_flags_t flags
);
   logic run_s, run_j, pat_s, pat_j;

   rct_run_tracker #(
      .SINGLE_LIMIT (SINGLE_RUN_LIMIT),
      .JOINT_LIMIT  (JOINT_RUN_LIMIT)
   ) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (clear),
      .take        (take),
      .bit_in      (bit_in),
      .over_single (run_s),
      .over_joint  (run_j)
   );

   generate
      if (PAT_TEST_EN) begin : g_pat
         rct_pair_tracker #(
            .SINGLE_LIMIT (SINGLE_PAT_LIMIT),
            .JOINT_LIMIT  (JOINT_PAT_LIMIT)
         ) u_pair (
            .clk         (clk),
            .rst_n       (rst_n),
            .clear       (clear),
            .take        (take),
            .bit_in      (bit_in),
            .over_single (pat_s),
            .over_joint  (pat_j)
         );
      end else begin : g_no_pat
         assign pat_s = 1'b0;
         assign pat_j = 1'b0;
      end
   endgenerate

   assign flags = '{run_single: run_s, run_joint: run_j,
                    pat_single: pat_s, pat_joint: pat_j};
endmodule

// File: rtl/rct_verdict.sv
module rct_verdict #(
   parameter int unsigned NUM_SRC = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               recover,
   input  logic [NUM_SRC-1:0] single_hit,
   input  logic [NUM_SRC-1:0] joint_run,
   input  logic [NUM_SRC-1:0] joint_pat,
   output logic               seed_err,
   output logic               err_pulse
);
   logic hit;

   assign hit = enable & ~recover & ((|single_hit) | (&joint_run) | (&joint_pat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_err  <= 1'b0;
         err_pulse <= 1'b0;
      end else if (recover) begin
         seed_err  <= 1'b0;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= hit & ~seed_err;
         if (hit)
            seed_err <= 1'b1;
      end
   end
endmodule

// File: rtl/rct_seed_monitor.sv
module rct_seed_monitor
   import rct_pkg::*;
#(
   parameter int unsigned NUM_SRC          = 2,
   parameter int unsigned SINGLE_RUN_LIMIT = 64,
   parameter int unsigned SINGLE_PAT_LIMIT = 32,
   parameter int unsigned JOINT_RUN_LIMIT  = 32,
   parameter int unsigned JOINT_PAT_LIMIT  = 16,
   parameter bit          PAT_TEST_EN      = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               recover,
   input  logic               sample_valid,
   input  logic [NUM_SRC-1:0] sample_bits,
   output logic               seed_err,
   output logic               err_pulse
);
   generate
      if (NUM_SRC < 2) begin : g_chk_src
         $error("rct_seed_monitor: NUM_SRC must be at least 2");
      end
      if (JOINT_RUN_LIMIT >= SINGLE_RUN_LIMIT || JOINT_RUN_LIMIT == 0) begin : g_chk_run
         $error("rct_seed_monitor: joint run limit must be nonzero and below single limit");
      end
      if (JOINT_PAT_LIMIT >= SINGLE_PAT_LIMIT || JOINT_PAT_LIMIT == 0) begin : g_chk_pat
         $error("rct_seed_monitor: joint pair limit must be nonzero and below single limit");
      end
   endgenerate

   logic               clear_all;
   logic               take;
   logic [NUM_SRC-1:0] single_hit;
   logic [NUM_SRC-1:0] joint_run;
   logic [NUM_SRC-1:0] joint_pat;

   assign clear_all = recover | ~enable;
   assign take      = sample_valid & enable;

   generate
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
         lane_flags_t fl;

         rct_lane #(
            .SINGLE_RUN_LIMIT (SINGLE_RUN_LIMIT),
            .JOINT_RUN_LIMIT  (JOINT_RUN_LIMIT),
            .SINGLE_PAT_LIMIT (SINGLE_PAT_LIMIT),
            .JOINT_PAT_LIMIT  (JOINT_PAT_LIMIT),
            .PAT_TEST_EN      (PAT_TEST_EN)
         ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear_all),
            .take   (take),
            .bit_in (sample_bits[s]),
            .flags  (fl)
         );

         assign single_hit[s] = fl.run_single | fl.pat_single;
         assign joint_run[s]  = fl.run_joint;
         assign joint_pat[s]  = fl.pat_joint;
      end
   endgenerate

   rct_verdict #(
      .NUM_SRC (NUM_SRC)
   ) u_verdict (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .recover    (recover),
      .single_hit (single_hit),
      .joint_run  (joint_run),
      .joint_pat  (joint_pat),
      .seed_err   (seed_err),
      .err_pulse  (err_pulse)
   );
endmodule

// File: rtl/rct_seed_monitor_chk.sv
module rct_seed_monitor_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic recover,
   input logic seed_err,
   input logic err_pulse
);
   assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   assert_pulse_with_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> seed_err);

   assert_rise_has_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seed_err) |-> err_pulse);

   assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_err && !recover) |=> seed_err);

   assert_recover_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (!seed_err && !err_pulse));

   assert_idle_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !err_pulse);
endmodule

bind rct_seed_monitor rct_seed_monitor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .recover   (recover),
   .seed_err  (seed_err),
   .err_pulse (err_pulse)
);

// File: tb/rct_seed_monitor_tb.sv
module rct_seed_monitor_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       recover = 1'b0;
   logic       sample_valid = 1'b0;
   logic [1:0] sample_bits = 2'b00;
   logic       seed_err;
   logic       err_pulse;

   always #5 clk = ~clk;

   rct_seed_monitor u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .recover      (recover),
      .sample_valid (sample_valid),
      .sample_bits  (sample_bits),
      .seed_err     (seed_err),
      .err_pulse    (err_pulse)
   );

   typedef struct {
      logic  exp_err;
      int    exp_pulses;
      string req;
   } exp_t;

   exp_t  sb_q[$];
   int    checks = 0;
   int    errors = 0;
   int    pulse_total = 0;
   int    exp_total = 0;
   bit    done = 1'b0;

   // Monitor: count pulses, then pop and compare expectations
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && err_pulse) pulse_total++;
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (seed_err !== e.exp_err) begin
               errors++;
               $display("FAIL %s: seed_err=%0d expected %0d", e.req, seed_err, e.exp_err);
            end
            checks++;
            if (pulse_total != e.exp_pulses) begin
               errors++;
               $display("FAIL %s: pulse count=%0d expected %0d", e.req, pulse_total, e.exp_pulses);
            end
         end
      end
   end

   // Filler stream 0,0,1,1: never a long run, never an alternating pair
   function automatic logic fill(input int i);
      return logic'((i >> 1) & 1);
   endfunction

   task automatic send(input logic [1:0] b);
      @(negedge clk);
      sample_valid = 1'b1;
      sample_bits  = b;
   endtask

   task automatic settle_and_expect(input logic e, input string req);
      @(negedge clk);
      sample_valid = 1'b0;
      repeat (3) @(negedge clk);
      sb_q.push_back('{exp_err: e, exp_pulses: exp_total, req: req});
      repeat (2) @(negedge clk);
   endtask

   task automatic do_recover();
      @(negedge clk);
      sample_valid = 1'b0;
      recover = 1'b1;
      @(negedge clk);
      recover = 1'b0;
   endtask

   // n equal bits v on source 0, filler on source 1
   task automatic s0_const(input int n, input logic v);
      for (int i = 0; i < n; i++) send({fill(i), v});
   endtask

   task automatic fill_both(input int n);
      for (int i = 0; i < n; i++) send({fill(i), fill(i)});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      // R1: reset state
      sb_q.push_back('{exp_err: 1'b0, exp_pulses: 0, req: "R1 reset"});
      repeat (2) @(negedge clk);

      // R2: single-source constant run
      do_recover(); s0_const(64, 1'b1); fill_both(6);
      settle_and_expect(1'b0, "R2 64 equal bits");
      do_recover(); s0_const(65, 1'b1); fill_both(6); exp_total++;
      settle_and_expect(1'b1, "R2 65 equal bits");
      do_recover(); for (int i = 0; i < 65; i++) send({1'b0, fill(i)}); exp_total++;
      settle_and_expect(1'b1, "R2 65 zeros on source 1");

      // R3: single-source pair repeats (source 0 sends pair 10)
      do_recover();
      for (int i = 0; i < 64; i++) send({fill(i), logic'(~i[0])});
      fill_both(8);
      settle_and_expect(1'b0, "R3 32 pair repeats");
      do_recover();
      for (int i = 0; i < 66; i++) send({fill(i), logic'(~i[0])});
      fill_both(8); exp_total++;
      settle_and_expect(1'b1, "R3 33 pair repeats");

      // R4: joint constant run
      do_recover(); for (int i = 0; i < 32; i++) send(2'b11); fill_both(6);
      settle_and_expect(1'b0, "R4 32 joint equal bits");
      do_recover(); for (int i = 0; i < 33; i++) send(2'b00); fill_both(6); exp_total++;
      settle_and_expect(1'b1, "R4 33 joint equal bits");

      // R5: joint pair repeats (source 0 pair 01, source 1 pair 10)
      do_recover();
      for (int i = 0; i < 32; i++) send({logic'(~i[0]), logic'(i[0])});
      fill_both(6);
      settle_and_expect(1'b0, "R5 16 joint pair repeats");
      do_recover();
      for (int i = 0; i < 34; i++) send({logic'(~i[0]), logic'(i[0])});
      fill_both(6); exp_total++;
      settle_and_expect(1'b1, "R5 17 joint pair repeats");

      // R6: a differing bit restarts the run
      do_recover(); s0_const(63, 1'b1); send(2'b00); s0_const(64, 1'b1); fill_both(6);
      settle_and_expect(1'b0, "R6 run restart");

      // R7: sticky status, recover clears status and counts
      do_recover(); s0_const(65, 1'b1); exp_total++; fill_both(20);
      settle_and_expect(1'b1, "R7 status held");
      do_recover();
      settle_and_expect(1'b0, "R7 recover clears status");
      s0_const(40, 1'b1); do_recover(); s0_const(40, 1'b1); fill_both(4);
      settle_and_expect(1'b0, "R7 recover clears counts");

      // R8: sustained fault gives one pulse only
      do_recover(); s0_const(200, 1'b1); exp_total++;
      settle_and_expect(1'b1, "R8 single pulse on sustained fault");

      // R9: valid-low samples ignored
      do_recover(); s0_const(60, 1'b1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk); sample_valid = 1'b0; sample_bits = 2'b00;
      end
      s0_const(4, 1'b1);
      settle_and_expect(1'b0, "R9 gaps ignored, 64 taken");
      s0_const(1, 1'b1); exp_total++;
      settle_and_expect(1'b1, "R9 65th taken bit trips");
      // R9: low enable clears counts and ignores samples
      do_recover(); s0_const(40, 1'b1);
      @(negedge clk); sample_valid = 1'b0; enable = 1'b0;
      @(negedge clk); enable = 1'b1;
      s0_const(40, 1'b1); fill_both(4);
      settle_and_expect(1'b0, "R9 enable low clears counts");
      @(negedge clk); enable = 1'b0;
      s0_const(70, 1'b1);
      settle_and_expect(1'b0, "R9 samples ignored while disabled");
      @(negedge clk); enable = 1'b1;

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule